// File: doc/BRIEF.md
# ADC Conversion Sequencer (SPI Host)

This block is the host side of a serial link to an 8-bit successive-approximation converter that runs in external clock mode. A single start request carries a channel number, a polarity bit, an input-mode bit and a divider value. The block lowers chip select and builds a mode-0 serial clock from the system clock. It shifts out a 24-bit frame made of one control byte and two zero bytes, and it collects the 24 bits that come back.

The converter returns its 8-bit sample across the second and third received bytes. The sample sits behind two leading zero bits. The first received byte carries no data and is dropped. The block pulls the sample out of that position, raises chip select again, and pulses a done flag for one cycle. The result stays on its output until the next conversion completes. A cycle counter limits how long one conversion may stay busy. When the limit is reached the frame is aborted and a timeout flag is raised.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset: cs_n_o=1, sclk_o=0, busy_o=0, done_o=0, timeout_o=0, result_o=0.
- R2: The first byte shifted out on mosi_o, MSB first, is {1, chan_i[2:0], unipolar_i, single_i, 1, 1}: bit 7 is the start marker, bits 6..4 are the channel, bit 3 is polarity, bit 2 is input mode, and bits 1..0 are both 1. mosi_o changes only when sclk_o falls or when cs_n_o falls.
- R3: Each conversion gives exactly 24 rising edges of sclk_o. The bits shifted out after the control byte are all zero.
- R4: Each high phase and each low phase of sclk_o lasts div_i+1 system cycles, with div_i latched at start. cs_n_o falls div_i+1 cycles before the first rising edge and rises div_i+1 cycles after the last falling edge. sclk_o idles low.
- R5: result_o = {rb2[5:0], rb3[7:6]}, where rb1, rb2 and rb3 are the three received bytes in order. rb1 and all other bits have no effect on result_o.
- R6: miso_i is sampled at the end of each low phase of sclk_o, just before the rising edge. This captures the bit that the converter presented after the previous falling edge.
- R7: A start_i accepted while idle sets busy_o on the next cycle. A start_i that arrives while busy_o=1 is ignored: the running frame is unchanged and no second conversion follows.
- R8: done_o is high for exactly one cycle, when cs_n_o rises at the end of a frame. result_o changes only in that cycle and holds until the next done.
- R9: If a conversion stays busy for TIMEOUT_CYC cycles, the block goes idle with cs_n_o=1 and sclk_o=0. It pulses timeout_o for one cycle, does not raise done_o, and leaves result_o unchanged.
- R10: sclk_o is high only while cs_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| chan_i | input | 3 | Channel select for the control byte |
| unipolar_i | input | 1 | 1 selects unipolar coding, 0 bipolar |
| single_i | input | 1 | 1 selects single-ended input, 0 differential |
| div_i | input | DIV_W | Half-period of the serial clock minus one, in system cycles |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 8 | Last converted sample |
| timeout_o | output | 1 | One-cycle pulse when a frame is aborted |
| sclk_o | output | 1 | Serial clock, mode 0 |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |

## Verification
The bench goes after the 2-bit offset of the result. It uses byte patterns where rb1 and the six trailing bits of rb3 are the complement of the wanted data, so a design that slices the wrong window or keeps the first byte returns a visibly wrong code. It measures every phase of sclk_o at divider values from 0 to 12; a design off by one in its reload shows a wrong phase length, and one that samples miso on the wrong side of the edge shifts the result by a bit. A start pulse is sent in the middle of a frame, which exposes a design that restarts or queues a second frame. A slow divider runs into the cycle limit, which shows whether the abort keeps the old result and raises no done.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 3;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int BIT_CNT_W   = $clog2(FRAME_BITS);
    localparam int LEAD_ZEROS  = 2;
    localparam int RES_LSB     = BYTE_W - LEAD_ZEROS;
    localparam int RX_KEEP     = RES_LSB + BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        seq_state_e            st;
        logic [BIT_CNT_W-1:0]  bitn;
        logic                  sclk;
        logic                  cs_n;
        logic                  done;
        logic                  tmo;
        logic [BYTE_W-1:0]     res;
    } seq_reg_t;

    // start marker, channel, polarity, input mode, two mode bits for external clocking
    function automatic logic [BYTE_W-1:0] make_ctrl(input logic [2:0] ch,
                                                    input logic       uni,
                                                    input logic       sgl);
        return {1'b1, ch, uni, sgl, 2'b11};
    endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } tick_reg_t;

    tick_reg_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.div = div_i;
            d.cnt = div_i;
        end else if (q.cnt == '0) begin
            d.cnt = q.div;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tick_o = (q.cnt == '0);

    // R4
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= q.div);

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
    import adc_seq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic              shift_i,
    input  logic              take_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [BYTE_W-1:0] res_o
);

    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [RX_KEEP-1:0]    rx;
    } sh_reg_t;

    sh_reg_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.tx = {ctrl_i, {(FRAME_BITS-BYTE_W){1'b0}}};
        end else if (shift_i) begin
            d.tx = {q.tx[FRAME_BITS-2:0], 1'b0};
        end
        if (take_i) begin
            // only the last RX_KEEP bits survive; the leading byte falls off the top
            d.rx = {q.rx[RX_KEEP-2:0], miso_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign mosi_o = q.tx[FRAME_BITS-1];
    assign res_o  = q.rx[RES_LSB +: BYTE_W];

    // R2
    tx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(load_i && shift_i));

endmodule

// File: rtl/adc_seq_tmo.sv
module adc_seq_tmo #(
    parameter int TIMEOUT_CYC = 125000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);

    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)    cnt_d = '0;
        else if (run_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expire_o = run_i && !clear_i && (cnt_q == TMO_W'(TIMEOUT_CYC - 1));

    // R9
    tmo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> cnt_q < TMO_W'(TIMEOUT_CYC));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int TIMEOUT_CYC = 125000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [2:0]       chan_i,
    input  logic             unipolar_i,
    input  logic             single_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [7:0]       result_o,
    output logic             timeout_o,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             mosi_o,
    input  logic             miso_i
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

    seq_reg_t q, d;

    logic              tick;
    logic              tick_load;
    logic              tx_load;
    logic              tx_shift;
    logic              rx_take;
    logic              tmo_clr;
    logic              expire;
    logic [BYTE_W-1:0] rx_res;

    adc_seq_tick #(.DIV_W(DIV_W)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tick_load),
        .div_i  (div_i),
        .tick_o (tick)
    );

    adc_seq_shift shift_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (tx_load),
        .ctrl_i  (make_ctrl(chan_i, unipolar_i, single_i)),
        .shift_i (tx_shift),
        .take_i  (rx_take),
        .miso_i  (miso_i),
        .mosi_o  (mosi_o),
        .res_o   (rx_res)
    );

    adc_seq_tmo #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmo_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (tmo_clr),
        .run_i    (q.st != ST_IDLE),
        .expire_o (expire)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.tmo     = 1'b0;
        tick_load = 1'b0;
        tx_load   = 1'b0;
        tx_shift  = 1'b0;
        rx_take   = 1'b0;
        tmo_clr   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = ST_LOW;
                    d.cs_n    = 1'b0;
                    d.bitn    = '0;
                    tick_load = 1'b1;
                    tx_load   = 1'b1;
                    tmo_clr   = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    rx_take = 1'b1;
                    d.sclk  = 1'b1;
                    d.st    = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    d.sclk = 1'b0;
                    if (q.bitn == LAST_BIT) begin
                        d.st = ST_HOLD;
                    end else begin
                        d.bitn   = q.bitn + 1'b1;
                        tx_shift = 1'b1;
                        d.st     = ST_LOW;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                    d.res  = rx_res;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (expire) begin
            d.st   = ST_IDLE;
            d.cs_n = 1'b1;
            d.sclk = 1'b0;
            d.done = 1'b0;
            d.tmo  = 1'b1;
            d.res  = q.res;
            rx_take  = 1'b0;
            tx_shift = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
    assign result_o  = q.res;
    assign timeout_o = q.tmo;
    assign sclk_o    = q.sclk;
    assign cs_n_o    = q.cs_n;

    // R10
    sclk_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_o |-> !cs_n_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8
    res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> done_o);

    // R7
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

    // R9
    tmo_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> (!done_o && cs_n_o && !sclk_o));

    // R2
    mosi_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mosi_o) |-> ($fell(sclk_o) || $fell(cs_n_o)));

endmodule

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;

    localparam int TMO = 1500;

    typedef struct packed {
        logic [2:0] ch;
        logic       uni;
        logic       sgl;
        logic [7:0] div;
        logic [7:0] rb1;
        logic [7:0] rb2;
        logic [7:0] rb3;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 1'b1, 8'd1,  8'hFF, 8'h3F, 8'hC0},
        '{3'd5, 1'b0, 1'b1, 8'd3,  8'hA5, 8'h2A, 8'h80},
        '{3'd2, 1'b1, 1'b0, 8'd0,  8'hFF, 8'hC0, 8'h3F},
        '{3'd7, 1'b0, 1'b0, 8'd7,  8'h5A, 8'h15, 8'h40},
        '{3'd3, 1'b1, 1'b1, 8'd12, 8'h81, 8'h01, 8'hBF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan = '0;
    logic       uni = 1'b0;
    logic       sgl = 1'b0;
    logic [7:0] div = '0;
    logic       busy, done, tmo, sclk, cs_n, mosi, miso;
    logic [7:0] result;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    adc_conv_seq #(.DIV_W(8), .TIMEOUT_CYC(TMO)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .chan_i     (chan),
        .unipolar_i (uni),
        .single_i   (sgl),
        .div_i      (div),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result),
        .timeout_o  (tmo),
        .sclk_o     (sclk),
        .cs_n_o     (cs_n),
        .mosi_o     (mosi),
        .miso_i     (miso)
    );

    // converter model and bus monitor, all sampled mid-cycle
    logic [23:0] resp_word = '0;
    logic [23:0] sh = '0;
    logic [23:0] cap = '0;
    logic        prev_sclk = 1'b0;
    logic        prev_cs = 1'b1;
    int          nrise = 0;
    int          lo_run = 0;
    int          hi_run = 0;
    int          nbad = 0;
    int          ndone = 0;
    int          ntmo = 0;
    int          cur_div = 0;
    logic [7:0]  last_res = '0;

    assign miso = sh[23];

    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            sh = resp_word; cap = '0; nrise = 0; lo_run = 0; hi_run = 0;
        end
        if (!prev_sclk && sclk) begin
            cap = {cap[22:0], mosi};
            nrise++;
            if (lo_run != cur_div + 1) nbad++;
            hi_run = 0;
        end
        if (prev_sclk && !sclk) begin
            if (hi_run != cur_div + 1) nbad++;
            sh = {sh[22:0], 1'b0};
            lo_run = 0;
        end
        if (!prev_cs && cs_n) begin
            if (lo_run != cur_div + 1) nbad++;
            lo_run = 0;
        end
        if (sclk) hi_run++;
        else if (!cs_n) lo_run++;
        if (done) begin ndone++; last_res = result; end
        if (tmo) ntmo++;
        prev_sclk = sclk;
        prev_cs   = cs_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [2:0] c, input logic u, input logic s, input logic [7:0] dv,
                          input logic [23:0] rw);
        @(negedge clk);
        resp_word = rw;
        cur_div   = int'(dv);
        chan = c; uni = u; sgl = s; div = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            if (done || tmo) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d0, b0, t0;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n && !sclk && !busy && !done && !tmo && result == 8'h00, "R1",
            {cs_n, sclk, busy, done, tmo, result}, {1'b1, 12'h0});
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] ctrl, expr;
            d0 = ndone; b0 = nbad; t0 = ntmo;
            ctrl = {1'b1, VECS[v].ch, VECS[v].uni, VECS[v].sgl, 2'b11};
            expr = {VECS[v].rb2[5:0], VECS[v].rb3[7:6]};
            launch(VECS[v].ch, VECS[v].uni, VECS[v].sgl, VECS[v].div,
                   {VECS[v].rb1, VECS[v].rb2, VECS[v].rb3});
            chk(busy == 1'b1, "R7 busy after start", busy, 1);
            wait_end();
            chk(cap[23:16] == ctrl, "R2 control byte", cap[23:16], ctrl);
            chk(cap[15:0] == 16'h0 && nrise == 24, "R3 frame", {cap[15:0], nrise[7:0]}, {16'h0, 8'd24});
            chk(nbad == b0, "R4 phase lengths", nbad - b0, 0);
            chk(last_res == expr && result == expr, "R5 R6 result", result, expr);
            chk(ndone == d0 + 1 && ntmo == t0, "R8 single done pulse", ndone - d0, 1);
            chk(cs_n && !sclk && !busy, "R10 idle after frame", {cs_n, sclk, busy}, 3'b100);
        end

        // R7: start during busy is ignored
        d0 = ndone;
        launch(3'd1, 1'b1, 1'b1, 8'd2, {8'h00, 8'h2B, 8'hFF});
        repeat (40) @(negedge clk);
        chan = 3'd6; uni = 1'b0; sgl = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        chk(cap[23:16] == 8'h9F, "R7 frame unchanged", cap[23:16], 8'h9F);
        chk(result == 8'hAF, "R7 result", result, 8'hAF);
        repeat (300) @(negedge clk);
        chk(ndone == d0 + 1 && !busy && cs_n, "R7 no second frame", ndone - d0, 1);

        // R9: slow divider runs into the cycle limit
        held = result; d0 = ndone; t0 = ntmo;
        launch(3'd4, 1'b1, 1'b1, 8'd30, 24'h00FFFF);
        wait_end();
        chk(ntmo == t0 + 1 && ndone == d0, "R9 timeout without done", {ntmo - t0, ndone - d0}, {32'd1, 32'd0});
        chk(cs_n && !sclk && !busy, "R9 idle after abort", {cs_n, sclk, busy}, 3'b100);
        chk(result == held, "R9 result kept", result, held);

        // R5: a normal frame after the abort still converts
        launch(3'd0, 1'b0, 1'b1, 8'd4, {8'hFF, 8'h00, 8'h40});
        wait_end();
        chk(result == 8'h01, "R5 recovery after timeout", result, 8'h01);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule